// File: doc/BRIEF.md
# Canonical Signed-Digit Recoder with Cost Report

This block takes a signed two's-complement filter coefficient and rewrites it as a sum and difference of powers of two. The result comes out as two equal-width vectors. One vector flags the positions whose digit is +1. The other flags the positions whose digit is −1.

The work runs one digit per cycle in three phases:

- A least-significant-first pass builds the canonical form, in which no two nonzero digits are adjacent.
- A most-significant-first pass trades subtractions for additions. It does this without raising the number of nonzero digits, and it drops the extra top digit wherever that digit is not needed.
- A final scan totals the cost of building a constant multiplier from the digits.

The cost report has three figures. The adder count is the number of nonzero digits less one. The shift count is the sum of the positions of the nonzero digits. The code length is one more than the highest nonzero position. Neighbouring logic compares these figures when it chooses a multiplier-free structure for each tap of an interference-rejection filter.

A caller presents a coefficient together with a one-cycle start strobe, then waits for the one-cycle done pulse. The result and its costs stay on the outputs until the next accepted start.

Top module: `csd_recoder`

## Requirements
- R1: A start seen while the block is idle captures the coefficient. The done output then goes high for exactly one cycle, after the 3*COEF_W-2'th rising edge following the capturing edge (34 edges with COEF_W = 12).
- R2: While a conversion is running, and in the cycle that done is high, start and coef have no effect. The result and the done timing belong to the coefficient captured at the accepted start.
- R3: Bit i of posDigits set means digit +1 at weight 2^i, and bit i of negDigits set means digit −1 at weight 2^i. The signed sum of all digits equals the captured coefficient read as a COEF_W-bit two's-complement number. No position is set in both vectors.
- R4: The first pass gives every run of two or more consecutive ones a +1 one place above the run and a −1 at its lowest place. A lone one stays a +1. Negative values are handled through their sign extension, so no nonzero digits are adjacent after this pass.
- R5: The second pass visits k from COEF_W-3 down to 0. At each k it turns the digits at positions k+2, k+1, k from (+1, 0, −1) into (0, +1, +1), and each visit sees the digits already rewritten by earlier visits. With this pass, 3 gives +1 at positions 1 and 0, 211 gives +1 at positions 7, 6, 4, 1 and 0, and 231 keeps +1 at 8 and 3 with −1 at 5 and 0.
- R6: adderCount equals the number of nonzero digits minus one, and is 0 when the coefficient is zero. For example, 211 costs 4 and 231 costs 3.
- R7: shiftCount equals the sum of the positions of all nonzero digits. For example, 211 costs 18 and 231 costs 16.
- R8: codeLength equals the highest nonzero digit position plus one, and is 0 when the coefficient is zero. For example, 211 gives 8, 231 gives 9, and −2048 gives 12.
- R9: After the done pulse, the digit vectors and the three cost figures keep their values until the next accepted start.
- R10: While reset is asserted, done is low and both digit vectors and all cost figures are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion; acted on only when idle |
| coef | input | COEF_W (12) | Signed two's-complement coefficient, sampled with an accepted start |
| done | output | 1 | One-cycle pulse marking a finished conversion |
| posDigits | output | COEF_W (12) | Positions holding digit +1 |
| negDigits | output | COEF_W (12) | Positions holding digit −1 |
| adderCount | output | clog2(COEF_W+1) (4) | Adders needed for the shift-add product |
| shiftCount | output | clog2(COEF_W*(COEF_W-1)/2+1) (7) | Sum of the shift amounts |
| codeLength | output | clog2(COEF_W+1) (4) | Highest nonzero position plus one |

## Verification
The assertions assume four things:

- reset is applied once before the first start;
- COEF_W is at least 3, so the refinement window fits;
- start is a synchronous single-bit level;
- the output figures are only meaningful once done has been seen.

They make no assumption about when start arrives. The stimulus therefore changes start and coef only between rising edges. It deliberately raises start inside a conversion, in the done cycle, and continuously across several back-to-back runs, so that the ignored-start path of R2 is exercised together with the restart that follows each done.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Phase strobes sent from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // capture coefficient, clear results
    logic recode;  // low-to-high canonical recoding step
    logic refine;  // high-to-low refinement step
    logic tally;   // cost accumulation step
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECODE,
    ST_REFINE,
    ST_TALLY,
    ST_FINISH
  } seqState_t;

endpackage

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
#(
  parameter int unsigned COEF_W = 12,
  localparam int unsigned IDX_W = $clog2(COEF_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COEF_W - 1);
  localparam logic [IDX_W-1:0] REF_TOP  = IDX_W'(COEF_W - 3);

  seqState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RECODE;
            idx   <= '0;
          end
        end
        ST_RECODE: begin
          if (idx == LAST_IDX) begin
            state <= ST_REFINE;
            idx   <= REF_TOP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_REFINE: begin
          if (idx == '0) begin
            state <= ST_TALLY;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        ST_TALLY: begin
          if (idx == LAST_IDX) begin
            state <= ST_FINISH;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.recode = (state == ST_RECODE);
    strobes.refine = (state == ST_REFINE);
    strobes.tally  = (state == ST_TALLY);
    done           = (state == ST_FINISH);
  end

  // done is a single-cycle pulse
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // at most one phase active in any cycle
  p_phase_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.recode, strobes.refine, strobes.tally, done}));

  // a start during the done cycle does not begin a new run
  p_start_after_done_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !strobes.recode);

endmodule

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
#(
  parameter int unsigned COEF_W = 12,
  localparam int unsigned IDX_W   = $clog2(COEF_W),
  localparam int unsigned CNT_W   = $clog2(COEF_W + 1),
  localparam int unsigned SHIFT_W = $clog2(COEF_W * (COEF_W - 1) / 2 + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   idx,
  input  logic [COEF_W-1:0]  coef,
  output logic [COEF_W-1:0]  posD,
  output logic [COEF_W-1:0]  negD,
  output logic [CNT_W-1:0]   nzCnt,
  output logic [SHIFT_W-1:0] shiftAcc,
  output logic [CNT_W-1:0]   lenR
);

  logic [COEF_W-1:0] coefR;
  logic              carry;

  // sign-extended view so the top step sees the sign as its upper neighbour
  logic [COEF_W:0] coefExt;
  logic [IDX_W:0]  idxP1;
  logic [IDX_W:0]  idxP2;
  logic            curBit;
  logic            nextBit;
  logic            oddSum;
  logic            matchRefine;
  logic            digitNz;

  always_comb begin
    coefExt     = {coefR[COEF_W-1], coefR};
    idxP1       = {1'b0, idx} + 1'b1;
    idxP2       = {1'b0, idx} + 2'd2;
    curBit      = coefExt[idx];
    nextBit     = coefExt[idxP1];
    oddSum      = curBit ^ carry;
    matchRefine = posD[idxP2] & ~posD[idxP1] & ~negD[idxP1] & negD[idx];
    digitNz     = posD[idx] | negD[idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefR    <= '0;
      carry    <= 1'b0;
      posD     <= '0;
      negD     <= '0;
      nzCnt    <= '0;
      shiftAcc <= '0;
      lenR     <= '0;
    end else if (strobes.load) begin
      coefR    <= coef;
      carry    <= 1'b0;
      posD     <= '0;
      negD     <= '0;
      nzCnt    <= '0;
      shiftAcc <= '0;
      lenR     <= '0;
    end else if (strobes.recode) begin
      if (oddSum) begin
        if (nextBit) begin
          negD[idx] <= 1'b1;  // bottom of a run of ones
          carry     <= 1'b1;
        end else begin
          posD[idx] <= 1'b1;  // lone one or top of a run
          carry     <= 1'b0;
        end
      end else begin
        carry <= curBit;      // two ones meet: carry stays, otherwise clears
      end
    end else if (strobes.refine) begin
      if (matchRefine) begin
        posD[idxP2] <= 1'b0;
        posD[idxP1] <= 1'b1;
        posD[idx]   <= 1'b1;
        negD[idx]   <= 1'b0;
      end
    end else if (strobes.tally) begin
      if (digitNz) begin
        nzCnt    <= nzCnt + 1'b1;
        shiftAcc <= shiftAcc + SHIFT_W'(idx);
        lenR     <= CNT_W'(idx) + 1'b1;
      end
    end
  end

  // a position never carries both signs
  p_digits_disjoint_r3: assert property (@(posedge clk) disable iff (!rstN)
    (posD & negD) == '0);

  // after the first pass no two nonzero digits touch
  p_nonadjacent_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.recode) |-> (((posD | negD) & ((posD | negD) >> 1)) == '0));

  // refinement keeps the number of nonzero digits
  p_refine_keeps_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refine |=> $countones(posD | negD) == $past($countones(posD | negD)));

  // refinement never adds a subtraction
  p_refine_no_new_neg_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refine |=> $countones(negD) <= $past($countones(negD)));

  // with no phase active the result registers hold
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load | strobes.recode | strobes.refine | strobes.tally)
      |=> $stable(posD) && $stable(negD) && $stable(nzCnt) && $stable(shiftAcc) && $stable(lenR));

endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
  import csd_pkg::*;
#(
  parameter int unsigned COEF_W = 12,
  localparam int unsigned IDX_W   = $clog2(COEF_W),
  localparam int unsigned CNT_W   = $clog2(COEF_W + 1),
  localparam int unsigned SHIFT_W = $clog2(COEF_W * (COEF_W - 1) / 2 + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COEF_W-1:0]  coef,
  output logic               done,
  output logic [COEF_W-1:0]  posDigits,
  output logic [COEF_W-1:0]  negDigits,
  output logic [CNT_W-1:0]   adderCount,
  output logic [SHIFT_W-1:0] shiftCount,
  output logic [CNT_W-1:0]   codeLength
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] nzCnt;

  csd_ctrl #(.COEF_W(COEF_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .idx     (idx),
    .done    (done)
  );

  csd_datapath #(.COEF_W(COEF_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .idx      (idx),
    .coef     (coef),
    .posD     (posDigits),
    .negD     (negDigits),
    .nzCnt    (nzCnt),
    .shiftAcc (shiftCount),
    .lenR     (codeLength)
  );

  assign adderCount = (nzCnt == '0) ? '0 : nzCnt - 1'b1;

  // adder figure tracks the digit vectors at completion
  p_adders_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    done && ((posDigits | negDigits) != '0)
      |-> int'(adderCount) + 1 == $countones(posDigits | negDigits));

  // nothing nonzero sits at or above the reported length
  p_length_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((posDigits | negDigits) >> codeLength) == '0);

  // an all-zero encoding costs nothing
  p_zero_cost_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && ((posDigits | negDigits) == '0)
      |-> codeLength == '0 && shiftCount == '0 && adderCount == '0);

endmodule

// File: tb/csd_recoder_tb_top.sv
module csd_recoder_tb_top;

  localparam int W       = 12;
  localparam int LAT     = 3 * W - 2;
  localparam int CNT_W   = $clog2(W + 1);
  localparam int SHIFT_W = $clog2(W * (W - 1) / 2 + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rstN;
  logic               start;
  logic [W-1:0]       coef;
  logic               done;
  logic [W-1:0]       posDigits;
  logic [W-1:0]       negDigits;
  logic [CNT_W-1:0]   adderCount;
  logic [SHIFT_W-1:0] shiftCount;
  logic [CNT_W-1:0]   codeLength;

  csd_recoder #(.COEF_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .coef(coef), .done(done),
    .posDigits(posDigits), .negDigits(negDigits), .adderCount(adderCount),
    .shiftCount(shiftCount), .codeLength(codeLength)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int         cnt = 0;
  bit         expDone = 0;
  bit         resValid = 0;
  int         mCoef = 0;
  logic [W-1:0] mPos = '0;
  logic [W-1:0] mNeg = '0;
  int         mAdd = 0;
  int         mShift = 0;
  int         mLen = 0;
  int         lcg = 32'h1234_5678;

  function automatic void buildModel(int c);
    int d[W];
    int v = c;
    int nz = 0;
    for (int i = 0; i < W; i++) begin
      if ((v & 1) != 0) begin
        d[i] = ((v & 3) == 1) ? 1 : -1;
        v = (v - d[i]) / 2;
      end else begin
        d[i] = 0;
        v = v / 2;
      end
    end
    for (int k = W - 3; k >= 0; k--) begin
      if (d[k+2] == 1 && d[k+1] == 0 && d[k] == -1) begin
        d[k+2] = 0; d[k+1] = 1; d[k] = 1;
      end
    end
    mPos = '0; mNeg = '0; mShift = 0; mLen = 0;
    for (int i = 0; i < W; i++) begin
      if (d[i] == 1)  mPos[i] = 1'b1;
      if (d[i] == -1) mNeg[i] = 1'b1;
      if (d[i] != 0) begin
        nz++;
        mShift += i;
        mLen = i + 1;
      end
    end
    mAdd = (nz == 0) ? 0 : nz - 1;
    mCoef = c;
  endfunction

  task automatic note(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    string hold;
    int sum;
    hold = expDone ? "" : "R9 ";
    note(done == expDone, "R1 R2", "done", int'(done), int'(expDone));
    if (resValid) begin
      note(posDigits == mPos, {hold, "R4 R5"}, "posDigits", int'(posDigits), int'(mPos));
      note(negDigits == mNeg, {hold, "R4 R5"}, "negDigits", int'(negDigits), int'(mNeg));
      note(int'(adderCount) == mAdd, {hold, "R6"}, "adderCount", int'(adderCount), mAdd);
      note(int'(shiftCount) == mShift, {hold, "R7"}, "shiftCount", int'(shiftCount), mShift);
      note(int'(codeLength) == mLen, {hold, "R8"}, "codeLength", int'(codeLength), mLen);
      if (expDone) begin
        sum = 0;
        for (int i = 0; i < W; i++) begin
          if (posDigits[i]) sum += (1 << i);
          if (negDigits[i]) sum -= (1 << i);
        end
        note(sum == mCoef, "R3", "digit sum", sum, mCoef);
        note((posDigits & negDigits) == '0, "R3", "overlap", int'(posDigits & negDigits), 0);
      end
    end
  endtask

  task automatic tick(bit st, int c);
    bit accept;
    start = st;
    coef  = c[W-1:0];
    accept = (cnt == 0) && !expDone && st;
    if (cnt > 0) begin
      cnt--;
      expDone = (cnt == 0);
      if (expDone) resValid = 1;
    end else begin
      expDone = 0;
    end
    if (accept) begin
      cnt = LAT;
      resValid = 0;
      buildModel($signed(c[W-1:0]));
    end
    @(negedge clk);
    checkOutputs();
  endtask

  task automatic runCoef(int c);
    tick(1, c);
    while (!(cnt == 0 && resValid && !expDone)) tick(0, 0);
    tick(0, 0);
  endtask

  function automatic int nextRand();
    int r;
    lcg = lcg * 1103515245 + 12345;
    r = (lcg >>> 8) & 4095;
    return (r >= 2048) ? r - 4096 : r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN  = 1'b0;
    start = 1'b0;
    coef  = '0;
    repeat (3) @(negedge clk);
    // R10: reset values, with start raised during reset
    start = 1'b1;
    coef  = 12'd211;
    @(negedge clk);
    note(done == 1'b0, "R10", "done in reset", int'(done), 0);
    note(posDigits == '0, "R10", "posDigits in reset", int'(posDigits), 0);
    note(negDigits == '0, "R10", "negDigits in reset", int'(negDigits), 0);
    note(adderCount == '0, "R10", "adderCount in reset", int'(adderCount), 0);
    note(shiftCount == '0, "R10", "shiftCount in reset", int'(shiftCount), 0);
    note(codeLength == '0, "R10", "codeLength in reset", int'(codeLength), 0);
    start = 1'b0;
    rstN  = 1'b1;
    @(negedge clk);

    // corner values and document examples (R4..R8)
    runCoef(0);
    runCoef(1);
    runCoef(3);
    runCoef(211);
    runCoef(231);
    runCoef(-2048);
    runCoef(2047);
    runCoef(-1);
    runCoef(-3);
    runCoef(-5);
    runCoef(11);
    runCoef(1365);
    runCoef(-1366);
    runCoef(1024);
    runCoef(-1025);

    // R2: start pulses inside a run and in the done cycle are ignored
    tick(1, 300);
    repeat (5) tick(0, 0);
    tick(1, -700);
    repeat (10) tick(0, 0);
    tick(1, 55);
    while (!expDone) tick(0, 0);
    tick(1, -9);           // start in the done cycle
    repeat (3) tick(0, 0);

    // R1 R2: start held high across back-to-back runs with changing coef
    for (int n = 0; n < 3 * (LAT + 2); n++) tick(1, nextRand());
    while (!(cnt == 0 && !expDone)) tick(0, 0);
    tick(0, 0);

    // varied patterns
    for (int n = 0; n < 60; n++) runCoef(nextRand());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule